// File: doc/BRIEF.md
# Interrupt Status and Clear Unit

This block collects interrupt causes for one disk-interface channel and presents them to software through a small word-addressed register window. Two causes are tracked as sticky pending bits. One is a completion interrupt from the attached device. The other is a bus fault raised while the channel moves data by DMA. Each cause has an enable bit. The unit drives a single request line that is high while any enabled cause is pending.

Software sees causes through the pending word. It turns sources on by writing ones into the enable word. It acknowledges causes by writing ones to the clear word. The unit also takes a strobe that marks a read of the channel's device status byte. When that byte shows the device is not busy, the read acknowledges every pending cause at once. When a bus fault is first reported, the unit keeps the 64-bit faulting address as two readable words. That address is held until the fault bit has been cleared.

`addr_i` carries a word index, not a byte offset.

Top module: `irq_unit`

## Requirements
- R1: After reset (`rst_ni` low) the pending, enable and fault-address words all read 0, and `irq_o` is low.
- R2: A one-cycle pulse on `dev_irq_i` sets pending bit 0. A pulse on `bus_err_i` sets pending bit 1. Both are visible at word 3 after the next clock edge and stay set with no further pulse.
- R3: A write to word 7 clears each pending bit whose position is 1 in `wdata_i`. Pending bits at 0 positions in the written data are left unchanged.
- R4: When a source pulse and a clear of the same bit fall in one cycle, the bit is set after the edge.
- R5: A write to word 5 ORs `wdata_i[1:0]` into the enable bits, and no write can lower them. Word 5 reads the enable bits in [1:0] and zero above.
- R6: `irq_o` equals the OR over both positions of (pending AND enable) at all times after reset.
- R7: When `stat_rd_i` is high and `dev_status_i[7]` (busy) is 0, both pending bits are cleared at the edge. When busy is 1, the strobe has no effect. A source pulse in the same cycle still wins.
- R8: A `bus_err_i` pulse while pending bit 1 is clear captures `err_addr_i`. The low 32 bits read at word 0 and the high 32 bits at word 1.
- R9: While pending bit 1 is set, further `bus_err_i` pulses leave the captured address unchanged. After bit 1 is cleared, the next fault captures again.
- R10: Writes to words 0, 1 and 3 and to unmapped words change no state. Reads of words 2, 4, 6, 7 and 8 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write |
| addr_i | input | 4 | Word index of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected word (0 when not reading) |
| dev_irq_i | input | 1 | Device interrupt pulse |
| bus_err_i | input | 1 | DMA bus fault pulse |
| err_addr_i | input | 64 | Address of the faulting DMA access |
| stat_rd_i | input | 1 | Device status byte is being read this cycle |
| dev_status_i | input | 8 | Device status byte; bit 7 is busy |
| irq_o | output | 1 | Interrupt request |

## Verification
A source pulse can land in the same cycle as either acknowledge path: a write to the clear word, or a status-byte read with busy low. The sweep reaches every such meeting by building each starting pending state. It then applies, in one cycle, every combination of source pulses, clear-word data, status strobe and busy bit, under three enable settings. The result is judged against an arithmetic model in which set beats clear and the fault address is taken only when bit 1 was clear before the edge.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int NSRC     = 2;
  localparam int SRC_DEV  = 0;
  localparam int SRC_BERR = 1;

  localparam int IDX_EADDR_LO = 0;
  localparam int IDX_EADDR_HI = 1;
  localparam int IDX_PEND     = 3;
  localparam int IDX_SET      = 5;
  localparam int IDX_CLR      = 7;

  typedef struct packed {
    logic wr_set;
    logic wr_clr;
  } wr_dec_t;
endpackage

// File: rtl/irq_regdec.sv
module irq_regdec
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NSRC-1:0]       pend_i,
  input  logic [NSRC-1:0]       en_i,
  input  logic [2*DATA_W-1:0]   eaddr_i,
  output wr_dec_t               dec_o,
  output logic [DATA_W-1:0]     rdata_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    dec_o.wr_set = wr && (addr_i == ADDR_W'(IDX_SET));
    dec_o.wr_clr = wr && (addr_i == ADDR_W'(IDX_CLR));
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        ADDR_W'(IDX_EADDR_LO): rdata_o = eaddr_i[DATA_W-1:0];
        ADDR_W'(IDX_EADDR_HI): rdata_o = eaddr_i[2*DATA_W-1:DATA_W];
        ADDR_W'(IDX_PEND):     rdata_o[NSRC-1:0] = pend_i;
        ADDR_W'(IDX_SET):      rdata_o[NSRC-1:0] = en_i;
        default:               rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_unit_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_data_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= src_i[i] | (pend_o[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     en_o[i] <= 1'b0;
      else if (en_wr_i && en_data_i[i]) en_o[i] <= 1'b1;
    end

    assign hit[i] = pend_o[i] & en_o[i];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/irq_errcap.sv
module irq_errcap #(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [2*DATA_W-1:0] addr_i,
  output logic [2*DATA_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (cap_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 8,
  parameter int BUSY_BIT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                dev_irq_i,
  input  logic                bus_err_i,
  input  logic [2*DATA_W-1:0] err_addr_i,
  input  logic                stat_rd_i,
  input  logic [STAT_W-1:0]   dev_status_i,
  output logic                irq_o
);
  localparam int EA_W = 2 * DATA_W;

  wr_dec_t         dec;
  logic [NSRC-1:0] pend_q, en_q, src, clr;
  logic [EA_W-1:0] eaddr_q;
  logic            stat_clr, cap;
  logic            unused_in;

  assign unused_in = ^{wdata_i[DATA_W-1:NSRC], dev_status_i};

  irq_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .pend_i  (pend_q),
    .en_i    (en_q),
    .eaddr_i (eaddr_q),
    .dec_o   (dec),
    .rdata_o (rdata_o)
  );

  // status read acknowledges only when the device is idle
  assign stat_clr = stat_rd_i & ~dev_status_i[BUSY_BIT];

  always_comb begin
    src           = '0;
    src[SRC_DEV]  = dev_irq_i;
    src[SRC_BERR] = bus_err_i;
    clr = (dec.wr_clr ? wdata_i[NSRC-1:0] : '0) | {NSRC{stat_clr}};
  end

  irq_pending u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src),
    .clr_i     (clr),
    .en_wr_i   (dec.wr_set),
    .en_data_i (wdata_i[NSRC-1:0]),
    .pend_o    (pend_q),
    .en_o      (en_q),
    .irq_o     (irq_o)
  );

  assign cap = bus_err_i & ~pend_q[SRC_BERR];

  irq_errcap #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .addr_i (err_addr_i),
    .addr_o (eaddr_q)
  );
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 8,
  parameter int BUSY_BIT = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                dev_irq_i,
  input logic                bus_err_i,
  input logic [2*DATA_W-1:0] err_addr_i,
  input logic                stat_rd_i,
  input logic [STAT_W-1:0]   dev_status_i,
  input logic                irq_o,
  input logic [NSRC-1:0]     pend_q,
  input logic [NSRC-1:0]     en_q,
  input logic [2*DATA_W-1:0] eaddr_q
);
  a_r2_dev_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_i |=> pend_q[SRC_DEV]);

  a_r4_err_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> pend_q[SRC_BERR]);

  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(IDX_CLR) && wdata_i[SRC_DEV] && !dev_irq_i)
      |=> !pend_q[SRC_DEV]);

  a_r7_stat_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !dev_status_i[BUSY_BIT] && !dev_irq_i && !bus_err_i)
      |=> pend_q == '0);

  a_r5_en_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (en_q & $past(en_q)) == $past(en_q));

  a_r6_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(pend_q & en_q));

  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_i && !pend_q[SRC_BERR]) |=> eaddr_q == $past(err_addr_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[SRC_BERR] |=> $stable(eaddr_q));
endmodule

bind irq_unit irq_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .BUSY_BIT(BUSY_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .dev_irq_i    (dev_irq_i),
  .bus_err_i    (bus_err_i),
  .err_addr_i   (err_addr_i),
  .stat_rd_i    (stat_rd_i),
  .dev_status_i (dev_status_i),
  .irq_o        (irq_o),
  .pend_q       (pend_q),
  .en_q         (en_q),
  .eaddr_q      (eaddr_q)
);

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        dev_irq_i = 1'b0, bus_err_i = 1'b0;
  logic [63:0] err_addr_i = '0;
  logic        stat_rd_i = 1'b0;
  logic [7:0]  dev_status_i = '0;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0]  pm = '0, em = '0;
  logic [63:0] am = '0;

  always #10 clk_i = ~clk_i;

  irq_unit u_irq_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .dev_irq_i(dev_irq_i), .bus_err_i(bus_err_i), .err_addr_i(err_addr_i),
    .stat_rd_i(stat_rd_i), .dev_status_i(dev_status_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr_i = a; req_i = 1'b1; we_i = 1'b0;
    #1 v = rdata_o;
    req_i = 1'b0;
  endtask

  // one clock with the given stimulus; starts and ends at negedge
  task automatic step(input logic d, input logic b, input logic [63:0] ea,
                      input logic sr, input logic bsy,
                      input logic w, input logic [3:0] wa, input logic [31:0] wd);
    logic [1:0] clr;
    dev_irq_i = d; bus_err_i = b; err_addr_i = ea;
    stat_rd_i = sr; dev_status_i = {bsy, 7'h2a};
    req_i = w; we_i = w; addr_i = wa; wdata_i = wd;
    @(posedge clk_i);
    clr = ((w && wa == 4'd7) ? wd[1:0] : 2'b00) | ((sr && !bsy) ? 2'b11 : 2'b00);
    if (b && !pm[1]) am = ea;
    pm = {b, d} | (pm & ~clr);
    if (w && wa == 4'd5) em = em | wd[1:0];
    @(negedge clk_i);
    dev_irq_i = 0; bus_err_i = 0; stat_rd_i = 0; req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic check_all(input string ptag);
    logic [31:0] v;
    rd(4'd3, v); chk(ptag, v, {30'd0, pm});
    chk("R6 irq_o", {31'd0, irq_o}, {31'd0, |(pm & em)});
    rd(4'd5, v); chk("R5 enable word", v, {30'd0, em});
    rd(4'd0, v); chk("R8/R9 addr lo", v, am[31:0]);
    rd(4'd1, v); chk("R8/R9 addr hi", v, am[63:32]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] ea;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check_all("R1 pending after reset");

    // R10 writes to read-only and unmapped words
    step(0, 0, '0, 0, 0, 1, 4'd3, 32'hffff_ffff);
    step(0, 0, '0, 0, 0, 1, 4'd0, 32'hffff_ffff);
    step(0, 0, '0, 0, 0, 1, 4'd1, 32'hffff_ffff);
    step(0, 0, '0, 0, 0, 1, 4'd12, 32'hffff_ffff);
    check_all("R10 pending after RO writes");
    step(1, 1, 64'h1234_5678_9abc_def0, 0, 0, 0, '0, '0);
    for (int a = 2; a < 16; a++) begin
      if (a == 3 || a == 5) continue;
      rd(4'(a), v);
      chk($sformatf("R10 read word %0d", a), v, 32'd0);
    end
    check_all("R2 pending set");

    // R9 hold then recapture
    step(0, 1, 64'hdead_beef_0000_0001, 0, 0, 0, '0, '0);
    check_all("R9 pending held");
    step(0, 0, '0, 0, 0, 1, 4'd7, 32'h2);
    check_all("R3 clear bit1 only");
    step(0, 1, 64'h0bad_f00d_5555_aaaa, 0, 0, 0, '0, '0);
    check_all("R9 recapture");

    // sweep: enable stage x start pending x clear data x sources x status read x busy
    for (int es = 0; es < 3; es++) begin
      step(0, 0, '0, 0, 0, 1, 4'd5, 32'hffff_fff0 | 32'(es));
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 4; s++)
            for (int sr = 0; sr < 2; sr++)
              for (int bsy = 0; bsy < 2; bsy++) begin
                ea = {16'(es), 8'(p), 8'(c), 8'(s), 8'(sr), 16'(bsy) ^ 16'h5a5a};
                step(0, 0, '0, 0, 0, 1, 4'd7, 32'h3);
                step(p[0], p[1], ~ea, 0, 0, 0, '0, '0);
                step(s[0], s[1], ea, sr[0], bsy[0], 1, 4'd7, 32'(c));
                check_all("R3/R4/R7 pending");
                step(0, 0, '0, 0, 0, 0, '0, '0);
                rd(4'd3, v); chk("R2 sticky", v, {30'd0, pm});
              end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule